// File: doc/BRIEF.md
# NAND Host Bus Bridge

This block links a 16-bit register-mapped host bus to an 8-bit NAND flash device. Software steers the NAND control lines (chip enable, command latch, address latch, write protect release) through a mode register, then moves bytes through a data port. The block turns each data-port access into NAND byte cycles with timed read or write strobes and stalls the host with a wait signal until the last strobe has finished. A 16-bit access becomes two byte cycles and an 8-bit access becomes one.

The NAND ready/busy line is synchronised, shown as a busy flag in a status register, and its busy-to-ready edge latches a pending flag in an interrupt status register. An interrupt mask register gates that flag onto the interrupt output. A driver typically clears pending flags, opens the mask, starts a long program or erase, and sleeps until the interrupt fires.

Top module: `nand_bridge_top`

## Requirements
- R1: Register offsets on `host_addr`: 0 data port, 4 mode, 5 status, 6 interrupt status, 7 interrupt mask. Mode and mask read back the last value written. Offsets 1 to 3 read as zero and ignore writes. Register accesses complete without wait.
- R2: Mode bit 0 drives `nand_cle`, bit 1 drives `nand_ale`, bit 4 set drives `nand_ce_n` low, bit 7 drives `nand_wp_n` high. So 0x94 is data mode, 0x95 command mode and 0x96 address mode.
- R3: Writing 0x00 to the mode register releases chip enable (`nand_ce_n` = 1) with `nand_cle` and `nand_ale` low.
- R4: Status bit 7 reads 1 while the synchronised ready/busy line is low (busy). The other status bits read 0. Two clocks of synchroniser latency apply.
- R5: A 16-bit write to the data port emits two NAND write cycles: bits 7:0 first, then bits 15:8.
- R6: A 16-bit read of the data port performs two NAND read cycles. The first byte is returned in bits 7:0 and the second in bits 15:8.
- R7: An 8-bit write to the data port emits exactly one NAND write cycle of bits 7:0. An 8-bit read performs one read cycle and returns the byte in bits 7:0 with bits 15:8 zero.
- R8: Each byte cycle holds its strobe (`nand_we_n` or `nand_re_n`) low for exactly `STROBE_CLKS` clocks, followed by one recovery clock. The two strobes are never low together. `host_wait` stays high while any strobe is low.
- R9: A low-to-high transition of the synchronised ready/busy line sets interrupt status bit 0. A high-to-low transition does not.
- R10: Interrupt status bits 3:0 are write-one-to-clear. Writing 0x0F clears all of them, a zero bit leaves its flag unchanged, and a new edge in the same clock wins over a clear.
- R11: `irq` is high when mask bit 7 is set and some interrupt status bit is set together with its mask bit in 3:0. A mask of 0x81 enables the ready interrupt and 0x00 disables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held until the wait is low |
| host_we | input | 1 | 1 write, 0 read |
| host_wide | input | 1 | 1 for a 16-bit data-port access, 0 for 8-bit |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid while wait is low |
| host_wait | output | 1 | Stall: the access is not yet complete |
| irq | output | 1 | Ready interrupt |
| nand_ce_n | output | 1 | NAND chip enable, active low |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ale | output | 1 | NAND address latch enable |
| nand_wp_n | output | 1 | NAND write protect, high releases protection |
| nand_we_n | output | 1 | NAND write strobe, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| nand_dq_o | output | 8 | NAND data out |
| nand_dq_oe | output | 1 | NAND data output enable |
| nand_dq_i | input | 8 | NAND data in |
| nand_rb | input | 1 | NAND ready (1) / busy (0) |

## Verification
The bench targets byte ordering in wide transfers. A design that swapped the lanes would show the high byte first on the NAND bus, or return it in bits 7:0. Narrow accesses are checked for exactly one cycle and a zeroed upper half, which catches a design that still runs a second strobe. The ready edge logic is checked in both directions, since a level-sensitive or falling-edge design would flag the interrupt during busy. The write-one-to-clear and mask gating are checked so that a clear-on-any-write or ungated output shows up at `irq`. Strobe width is measured on every cycle, so an off-by-one in the strobe counter fails.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
    localparam int HOST_W = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int IRQ_SRC = 4;

    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_MODE = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_IPND = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_IMSK = 3'd7;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_STROBE,
        SQ_RECOVER,
        SQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic       wr_release;
        logic [1:0] spare_hi;
        logic       chip_sel;
        logic [1:0] spare_lo;
        logic       addr_latch;
        logic       cmd_latch;
    } mode_t;

    typedef struct packed {
        logic              we;
        logic              wide;
        logic [HOST_W-1:0] wdata;
    } xfer_t;

    function automatic logic is_data_ofs(input logic [ADDR_W-1:0] a);
        return a == OFS_DATA;
    endfunction
endpackage

// File: rtl/nbr_rb_sync.sv
module nbr_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rb_async,
    output logic rb_level,
    output logic rb_rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b1;
                    else     sync_q[0] <= rb_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b1;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign rb_level = sync_q[STAGES-1];
    assign rb_rise  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/nbr_regs.sv
module nbr_regs
    import nbr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic               rb_busy,
    input  logic               rb_rise,
    output mode_t              mode_q,
    output logic [IRQ_SRC-1:0] ipnd_q,
    output logic [BYTE_W-1:0]  imsk_q,
    output logic [BYTE_W-1:0]  rdata,
    output logic               irq
);
    logic [IRQ_SRC-1:0] clr_bits;
    logic [IRQ_SRC-1:0] set_bits;

    assign clr_bits = (reg_wr && addr == OFS_IPND) ? wdata[IRQ_SRC-1:0] : '0;
    assign set_bits = {{(IRQ_SRC-1){1'b0}}, rb_rise};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            imsk_q <= '0;
            ipnd_q <= '0;
        end else begin
            if (reg_wr && addr == OFS_MODE) mode_q <= mode_t'(wdata);
            if (reg_wr && addr == OFS_IMSK) imsk_q <= wdata;
            ipnd_q <= (ipnd_q & ~clr_bits) | set_bits;
        end
    end

    always_comb begin
        unique case (addr)
            OFS_MODE: rdata = mode_q;
            OFS_STAT: rdata = {rb_busy, {(BYTE_W-1){1'b0}}};
            OFS_IPND: rdata = {{(BYTE_W-IRQ_SRC){1'b0}}, ipnd_q};
            OFS_IMSK: rdata = imsk_q;
            default:  rdata = '0;
        endcase
    end

    assign irq = imsk_q[BYTE_W-1] & (|(ipnd_q & imsk_q[IRQ_SRC-1:0]));
endmodule

// File: rtl/nbr_seq.sv
module nbr_seq
    import nbr_pkg::*;
#(
    parameter int STROBE_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_t             xfer_i,
    input  logic [BYTE_W-1:0] dq_i,
    output logic [HOST_W-1:0] rd_word,
    output logic              done,
    output logic              we_n,
    output logic              re_n,
    output logic [BYTE_W-1:0] dq_o,
    output logic              dq_oe
);
    localparam int CNT_W = $clog2(STROBE_CLKS) + 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STROBE_CLKS - 1);

    seq_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic             second;
    xfer_t            cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            cnt     <= '0;
            second  <= 1'b0;
            cur     <= '0;
            rd_word <= '0;
        end else begin
            unique case (st)
                SQ_IDLE: begin
                    if (start) begin
                        cur    <= xfer_i;
                        second <= 1'b0;
                        cnt    <= CNT_LOAD;
                        st     <= SQ_STROBE;
                        if (!xfer_i.we) rd_word <= '0;
                    end
                end
                SQ_STROBE: begin
                    if (cnt == '0) begin
                        if (!cur.we) begin
                            if (second) rd_word[HOST_W-1:BYTE_W] <= dq_i;
                            else        rd_word[BYTE_W-1:0]      <= dq_i;
                        end
                        st <= SQ_RECOVER;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SQ_RECOVER: begin
                    if (cur.wide && !second) begin
                        second <= 1'b1;
                        cnt    <= CNT_LOAD;
                        st     <= SQ_STROBE;
                    end else begin
                        st <= SQ_DONE;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign done  = (st == SQ_DONE);
    assign we_n  = !(st == SQ_STROBE && cur.we);
    assign re_n  = !(st == SQ_STROBE && !cur.we);
    assign dq_oe = cur.we && (st == SQ_STROBE || st == SQ_RECOVER);
    assign dq_o  = second ? cur.wdata[HOST_W-1:BYTE_W] : cur.wdata[BYTE_W-1:0];
endmodule

// File: rtl/nand_bridge_top.sv
module nand_bridge_top
    import nbr_pkg::*;
#(
    parameter int STROBE_CLKS = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_wide,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    output logic              host_wait,
    output logic              irq,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_wp_n,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [BYTE_W-1:0] nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [BYTE_W-1:0] nand_dq_i,
    input  logic              nand_rb
);
    logic               data_sel;
    logic               reg_wr;
    logic               seq_start;
    logic               seq_done;
    logic [HOST_W-1:0]  rd_word;
    logic [BYTE_W-1:0]  reg_rdata;
    logic               rb_level;
    logic               rb_rise;
    mode_t              mode_q;
    logic [IRQ_SRC-1:0] ipnd_q;
    logic [BYTE_W-1:0]  imsk_q;
    xfer_t              xfer;

    assign data_sel  = is_data_ofs(host_addr);
    assign reg_wr    = host_req && host_we && !data_sel;
    assign seq_start = host_req && data_sel;
    assign host_wait = host_req && data_sel && !seq_done;
    assign xfer      = '{we: host_we, wide: host_wide, wdata: host_wdata};

    nbr_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .rb_async (nand_rb),
        .rb_level (rb_level),
        .rb_rise  (rb_rise)
    );

    nbr_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .reg_wr  (reg_wr),
        .addr    (host_addr),
        .wdata   (host_wdata[BYTE_W-1:0]),
        .rb_busy (!rb_level),
        .rb_rise (rb_rise),
        .mode_q  (mode_q),
        .ipnd_q  (ipnd_q),
        .imsk_q  (imsk_q),
        .rdata   (reg_rdata),
        .irq     (irq)
    );

    nbr_seq #(.STROBE_CLKS(STROBE_CLKS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (seq_start),
        .xfer_i  (xfer),
        .dq_i    (nand_dq_i),
        .rd_word (rd_word),
        .done    (seq_done),
        .we_n    (nand_we_n),
        .re_n    (nand_re_n),
        .dq_o    (nand_dq_o),
        .dq_oe   (nand_dq_oe)
    );

    assign host_rdata = data_sel ? rd_word : {{(HOST_W-BYTE_W){1'b0}}, reg_rdata};
    assign nand_ce_n  = !mode_q.chip_sel;
    assign nand_cle   = mode_q.cmd_latch;
    assign nand_ale   = mode_q.addr_latch;
    assign nand_wp_n  = mode_q.wr_release;
endmodule

// File: rtl/nbr_checker.sv
module nbr_checker
    import nbr_pkg::*;
#(
    parameter int STROBE_CLKS = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               host_req,
    input logic               host_we,
    input logic [ADDR_W-1:0]  host_addr,
    input logic [HOST_W-1:0]  host_wdata,
    input logic               host_wait,
    input logic               irq,
    input logic               nand_ce_n,
    input logic               nand_cle,
    input logic               nand_ale,
    input logic               nand_we_n,
    input logic               nand_re_n,
    input logic               rb_rise,
    input logic [IRQ_SRC-1:0] ipnd_q,
    input logic [BYTE_W-1:0]  imsk_q
);
    logic [15:0] low_run;
    logic        wr_mode;
    logic        wr_ipnd;

    assign wr_mode = host_req && host_we && !host_wait && host_addr == OFS_MODE;
    assign wr_ipnd = host_req && host_we && !host_wait && host_addr == OFS_IPND;

    always_ff @(posedge clk) begin
        if (rst)            low_run <= '0;
        else if (!nand_we_n) low_run <= low_run + 1'b1;
        else                low_run <= '0;
    end

    p_mode_ce_r2: assert property (@(posedge clk) disable iff (rst)
        wr_mode |=> (nand_ce_n == !$past(host_wdata[4])) && (nand_cle == $past(host_wdata[0])));

    p_standby_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_mode && host_wdata[7:0] == 8'h00) |=> (nand_ce_n && !nand_cle && !nand_ale));

    p_strobe_width_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_we_n) |-> (low_run == 16'(STROBE_CLKS)));

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    p_stall_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> host_wait);

    p_rise_sets_r9: assert property (@(posedge clk) disable iff (rst)
        rb_rise |=> ipnd_q[0]);

    p_w1c_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_ipnd && host_wdata[0] && !rb_rise) |=> !ipnd_q[0]);

    p_mask_gate_r11: assert property (@(posedge clk) disable iff (rst)
        !imsk_q[7] |-> !irq);
endmodule

bind nand_bridge_top nbr_checker #(.STROBE_CLKS(STROBE_CLKS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_wait  (host_wait),
    .irq        (irq),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .rb_rise    (rb_rise),
    .ipnd_q     (ipnd_q),
    .imsk_q     (imsk_q)
);

// File: tb/test_nand_bridge_top.sv
module test_nand_bridge_top;
    localparam int STROBE = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic        host_wide = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_wait;
    logic        irq;
    logic        nand_ce_n, nand_cle, nand_ale, nand_wp_n;
    logic        nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_o;
    logic [7:0]  nand_dq_i = '0;
    logic        nand_rb = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    logic [9:0] wlog [0:255];
    int         wcnt = 0;
    int         rptr = 0;
    int         low_cnt = 0;
    int         last_width = 0;

    always #4 clk = ~clk;

    nand_bridge_top #(.STROBE_CLKS(STROBE)) i_nand_bridge_top (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_wide(host_wide), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_wait(host_wait), .irq(irq),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_wp_n(nand_wp_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
        .nand_rb(nand_rb)
    );

    function automatic logic [7:0] flash_byte(input int idx);
        logic [7:0] v;
        v = 8'(idx * 29 + 59);
        return v ^ 8'(idx >> 3);
    endfunction

    function automatic logic [15:0] exp_wide_rd(input int p);
        return {flash_byte(p + 1), flash_byte(p)};
    endfunction

    always @(negedge nand_re_n) begin
        nand_dq_i = flash_byte(rptr);
        rptr++;
    end

    always @(posedge nand_we_n) begin
        if (wcnt < 256) wlog[wcnt] = {nand_cle, nand_ale, nand_dq_o};
        wcnt++;
    end

    always @(negedge clk) begin
        if (!nand_we_n || !nand_re_n) low_cnt++;
        else if (low_cnt != 0) begin
            last_width = low_cnt;
            low_cnt = 0;
        end
    end

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus(input logic we, input logic wide, input logic [2:0] a,
                       input logic [15:0] wd, output logic [15:0] rd);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_wide = wide;
        host_addr = a; host_wdata = wd;
        #1;
        while (host_wait) begin
            @(negedge clk);
            #1;
        end
        rd = host_rdata;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic wide = 1'b0);
        logic [15:0] dummy;
        bus(1'b1, wide, a, d, dummy);
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d, input logic wide = 1'b0);
        bus(1'b0, wide, a, 16'h0, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        report();
        $finish;
    end

    initial begin
        logic [15:0] r;
        int w0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state (R1, R2)
        check("R2 reset ce_n", nand_ce_n, 1);
        check("R8 reset strobes", {nand_we_n, nand_re_n}, 2'b11);
        check("R11 reset irq", irq, 0);
        rd(3'd4, r);
        check("R1 reset mode", r, 16'h0);
        rd(3'd5, r);
        check("R4 reset status ready", r, 16'h0);

        // command mode, one byte (R2, R7, R8)
        wr(3'd4, 16'h0095);
        check("R2 command mode lines", {nand_ce_n, nand_cle, nand_ale, nand_wp_n}, 4'b0101);
        rd(3'd4, r);
        check("R1 mode readback", r, 16'h0095);
        w0 = wcnt;
        wr(3'd0, 16'hAAFF, 1'b0);
        check("R7 narrow write count", wcnt - w0, 1);
        check("R7 narrow write byte", wlog[w0], {2'b10, 8'hFF});
        check("R8 strobe width", last_width, STROBE);

        // address mode, wide write (R2, R5)
        wr(3'd4, 16'h0096);
        check("R2 address mode lines", {nand_cle, nand_ale}, 2'b01);
        w0 = wcnt;
        wr(3'd0, 16'h3412, 1'b1);
        check("R5 wide write count", wcnt - w0, 2);
        check("R5 wide write first low", wlog[w0], {2'b01, 8'h12});
        check("R5 wide write second high", wlog[w0 + 1], {2'b01, 8'h34});

        // standby (R3)
        wr(3'd4, 16'h0000);
        check("R3 standby lines", {nand_ce_n, nand_cle, nand_ale, nand_wp_n}, 4'b1000);

        // data mode reads (R6, R7)
        wr(3'd4, 16'h0094);
        check("R2 data mode wp release", {nand_wp_n, nand_ce_n}, 2'b10);
        w0 = rptr;
        rd(3'd0, r, 1'b1);
        check("R6 wide read order", r, exp_wide_rd(w0));
        check("R8 read strobe width", last_width, STROBE);
        w0 = rptr;
        rd(3'd0, r, 1'b0);
        check("R7 narrow read", r, {8'h00, flash_byte(w0)});
        check("R7 narrow read one cycle", rptr - w0, 1);

        // unused offsets (R1)
        wr(3'd2, 16'h00FF);
        rd(3'd2, r);
        check("R1 unused offset", r, 16'h0);
        rd(3'd4, r);
        check("R1 unused write no effect on mode", r, 16'h0094);

        // ready interrupt (R4, R9, R10, R11)
        wr(3'd6, 16'h000F);
        wr(3'd7, 16'h0081);
        rd(3'd7, r);
        check("R1 mask readback", r, 16'h0081);
        nand_rb = 1'b0;
        repeat (4) @(negedge clk);
        rd(3'd5, r);
        check("R4 busy status", r, 16'h0080);
        rd(3'd6, r);
        check("R9 falling edge no flag", r, 16'h0);
        check("R11 no irq while busy", irq, 0);
        nand_rb = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd5, r);
        check("R4 ready status", r, 16'h0);
        rd(3'd6, r);
        check("R9 rising edge flag", r, 16'h0001);
        check("R11 irq enabled", irq, 1);
        wr(3'd7, 16'h0000);
        check("R11 irq masked", irq, 0);
        wr(3'd7, 16'h0001);
        check("R11 master bit needed", irq, 0);
        wr(3'd6, 16'h0000);
        rd(3'd6, r);
        check("R10 zero write keeps flag", r, 16'h0001);
        wr(3'd6, 16'h000F);
        rd(3'd6, r);
        check("R10 clear all", r, 16'h0);
        wr(3'd7, 16'h0081);
        check("R11 irq off after clear", irq, 0);

        // random data traffic in data mode (R5, R6, R7)
        void'($urandom(32'd1234));
        for (int i = 0; i < 40; i++) begin
            int op;
            logic [15:0] d;
            op = int'($urandom % 4);
            d = 16'($urandom);
            if (op == 0) begin
                w0 = wcnt;
                wr(3'd0, d, 1'b1);
                check("R5 random wide write", {wlog[w0][7:0], wlog[w0 + 1][7:0]}, {d[7:0], d[15:8]});
            end else if (op == 1) begin
                w0 = wcnt;
                wr(3'd0, d, 1'b0);
                check("R7 random narrow write", {22'(wcnt - w0), wlog[w0]}, {22'd1, 2'b00, d[7:0]});
            end else if (op == 2) begin
                w0 = rptr;
                rd(3'd0, r, 1'b1);
                check("R6 random wide read", r, exp_wide_rd(w0));
            end else begin
                w0 = rptr;
                rd(3'd0, r, 1'b0);
                check("R7 random narrow read", r, {8'h00, flash_byte(w0)});
            end
        end

        report();
        $finish;
    end
endmodule